// File: doc/BRIEF.md
# Dual-Function PCI Configuration Space Target

This block answers PCI Type 0 configuration reads and writes for a combined device that shows up on the bus as two separate single-function devices. Each function has its own select input and its own 64-byte header. An address phase arrives as a one-cycle request carrying the address, the direction, the byte enables and the write data. When exactly one select input is high and the low two address bits are zero, the block claims the cycle. It then updates or reads the chosen DWORD of that function's header. The claim indication and any read data appear one clock later.

Each header holds the identity fields, the command and status word, the revision and class code, the latency timer, the header type, one I/O base address register and the interrupt line and pin. Identity, status, class, header type and interrupt pin are fixed by parameters. The command word, latency timer, base address and interrupt line are writable. Only the command word returns to zero on hardware reset. Every other location is reserved: it reads as zero and ignores writes. Software reset and sleep inputs reach the block but leave every register as it is. Lane k of the data bus (bits 8k+7 down to 8k) carries the byte at offset 4*DWORD+k, so multi-byte fields are little-endian.

Top module: `cfg_space_target`

## Requirements
- R1: A request is claimed only when exactly one bit of `idsel` is 1 and `addr[1:0]` is 00. A claimed request drives `devsel` high in the cycle after the request. With no select bit or with both select bits high, `devsel` stays low and no register changes.
- R2: A request with `addr[1:0]` not equal to 00 is not a Type 0 access and is never claimed.
- R3: `addr[5:2]` selects the DWORD. `addr[31:8]`, including the function number in bits 10:8, has no effect. Requests with `addr[7:6]` not 00 are claimed, read zero and change nothing.
- R4: Write byte enable `be[k]` lets lane k update a writable field. On a read, lanes whose enable is 0 return zero. Read data appears on `rd_data` with `rd_valid` high one cycle after the request. Write requests leave `rd_valid` low and `rd_data` at zero.
- R5: DWORD 0 returns device ID in bits 31:16 and vendor ID in bits 15:0. DWORD 2 returns the class code in bits 31:8 and the revision in bits 7:0. Writes to either DWORD are discarded.
- R6: DWORD 1 bits 15:0 are the command register. Only the bits set in the command write mask (default 0145h) are writable. Bits 31:16 return the fixed status value (default 0280h).
- R7: In DWORD 3, bits 15:8 are a writable latency timer. Bits 23:16 are the header type and read 00h, so bit 23 (multi-function) is 0. Bits 7:0 and 31:24 read zero.
- R8: DWORD 4 is an I/O base address register for a 32-byte window. Bit 0 reads 1, bits 4:1 read 0, and bits 31:5 are writable. Writing FFFFFFFFh reads back FFFFFFE1h.
- R9: In DWORD 15, bits 7:0 are the writable interrupt line. Bits 15:8 are the fixed interrupt pin (function 0: 01h, function 1: 02h). Bits 31:16 read zero.
- R10: DWORDs 5 to 14 are reserved: they read zero and writes to them have no effect.
- R11: A hardware reset (`rst_n` low at a clock edge) clears the command register. The latency timer, base address and interrupt line keep their values.
- R12: `soft_rst` and `sleep` do not affect claiming, reads, writes or any register value.
- R13: The two functions hold separate headers. A write through one select input never changes the other function. Default IDs are vendor 5A17h, with device 0D10h for function 0 and 0D20h for function 1. Default class codes are 028000h and 010000h, and default revisions are 12h and 34h.
- R14: The first request after reset is served without waiting for any loading.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| soft_rst | input | 1 | Software reset request; has no effect on this block |
| sleep | input | 1 | Sleep request; has no effect on this block |
| req | input | 1 | Address phase of a configuration cycle, one cycle wide |
| we | input | 1 | 1 = write, 0 = read |
| idsel | input | NFUNC | Per-function select, one bit per function |
| addr | input | 32 | Address phase value |
| be | input | 4 | Active-high byte enables |
| wdata | input | 32 | Write data |
| devsel | output | 1 | Claim indication, one cycle after the request |
| rd_valid | output | 1 | Read data valid, one cycle after a claimed read |
| rd_data | output | 32 | Read data with disabled lanes zeroed |

## Verification
The collision that matters is a configuration write arriving in the same cycle as a software reset and a sleep request. The bench raises both inputs and, while they are high, writes the latency timer of function 0. It then reads back the command word and the latency timer. Both must hold the values written, which shows the write landed and nothing was cleared. A hardware reset is then applied on its own and the same locations are read again. Only the command word may have gone to zero.

// File: rtl/cfg_space_pkg.sv
// Shared constants and helpers for the configuration space target.
// Assumes a 32-bit data path with four byte lanes, lane k = bits 8k+7:8k.
package cfg_space_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;
    localparam int IDX_W  = 4;

    // DWORD indexes whose position the host software decodes
    localparam logic [IDX_W-1:0] DW_IDENT   = 4'd0;
    localparam logic [IDX_W-1:0] DW_CMDSTAT = 4'd1;
    localparam logic [IDX_W-1:0] DW_CLASS   = 4'd2;
    localparam logic [IDX_W-1:0] DW_MISC    = 4'd3;
    localparam logic [IDX_W-1:0] DW_IOBAR   = 4'd4;
    localparam logic [IDX_W-1:0] DW_IRQ     = 4'd15;

    // Expand byte enables into a bit mask
    function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] en);
        logic [DATA_W-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[8*k +: 8] = {8{en[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/cfg_decode.sv
// Address phase decoder: decides whether a request is claimed and which
// function and DWORD it targets. Assumes idsel is one bit per function;
// a request with zero or several select bits is not claimed.
module cfg_decode
    import cfg_space_pkg::*;
#(
    parameter int NFUNC = 2
) (
    input  logic             req,
    input  logic [7:0]       addr_lo,
    input  logic [NFUNC-1:0] idsel,
    output logic             claim,
    output logic [NFUNC-1:0] fsel,
    output logic [IDX_W-1:0] dw_idx,
    output logic             in_range
);

    logic one_sel;

    // Exactly one select bit high
    always_comb one_sel = (idsel != '0) && ((idsel & (idsel - 1'b1)) == '0);

    // Type 0 check and claim decision
    always_comb claim = req && one_sel && (addr_lo[1:0] == 2'b00);

    // Function select is only meaningful for a claimed request
    always_comb fsel = claim ? idsel : '0;

    // DWORD index and implemented-range flag
    always_comb begin
        dw_idx   = addr_lo[5:2];
        in_range = (addr_lo[7:6] == 2'b00);
    end

endmodule

// File: rtl/cfg_func_regs.sv
// One function's 64-byte configuration header. Fixed fields come from
// parameters; the command word is the only register with a reset. Assumes
// wr_en is a single-cycle strobe already qualified by claim and range, and
// BAR_LOG2 >= 2.
module cfg_func_regs
    import cfg_space_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h5A17,
    parameter logic [15:0] DEVICE_ID  = 16'h0D10,
    parameter logic [7:0]  REVISION   = 8'h12,
    parameter logic [23:0] CLASS_CODE = 24'h028000,
    parameter logic [15:0] STATUS_VAL = 16'h0280,
    parameter logic [15:0] CMD_WMASK  = 16'h0145,
    parameter logic [7:0]  IRQ_PIN    = 8'h01,
    parameter int          BAR_LOG2   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LANES-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int BAR_HI_W = DATA_W - BAR_LOG2;

    logic [15:0]         cmd_q;
    logic [7:0]          lat_q;
    logic [BAR_HI_W-1:0] bar_q;
    logic [7:0]          line_q;
    logic [DATA_W-1:0]   wmask;
    logic [15:0]         cmd_we;

    // Per-bit write enables from the byte lanes
    always_comb begin
        wmask  = lane_mask(be);
        cmd_we = CMD_WMASK & wmask[15:0];
    end

    // Command register: cleared by hardware reset, masked writable bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (wr_en && idx == DW_CMDSTAT) begin
            cmd_q <= (cmd_q & ~cmd_we) | (wdata[15:0] & cmd_we);
        end
    end

    // Latency timer: lane 1 of DWORD 3, survives reset
    always_ff @(posedge clk) begin
        if (wr_en && idx == DW_MISC && be[1]) begin
            lat_q <= wdata[15:8];
        end
    end

    // Base address upper bits: writable per lane, survive reset
    always_ff @(posedge clk) begin
        if (wr_en && idx == DW_IOBAR) begin
            bar_q <= (bar_q & ~wmask[DATA_W-1:BAR_LOG2]) |
                     (wdata[DATA_W-1:BAR_LOG2] & wmask[DATA_W-1:BAR_LOG2]);
        end
    end

    // Interrupt line: lane 0 of DWORD 15, survives reset
    always_ff @(posedge clk) begin
        if (wr_en && idx == DW_IRQ && be[0]) begin
            line_q <= wdata[7:0];
        end
    end

    // Read mux in little-endian lane order; reserved DWORDs read zero
    always_comb begin
        unique case (idx)
            DW_IDENT:   rdata = {DEVICE_ID, VENDOR_ID};
            DW_CMDSTAT: rdata = {STATUS_VAL, cmd_q};
            DW_CLASS:   rdata = {CLASS_CODE, REVISION};
            DW_MISC:    rdata = {8'h00, 8'h00, lat_q, 8'h00};
            DW_IOBAR:   rdata = {bar_q, {(BAR_LOG2-1){1'b0}}, 1'b1};
            DW_IRQ:     rdata = {16'h0000, IRQ_PIN, line_q};
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/cfg_space_target.sv
// Top of the dual-function configuration space target. Decodes the address
// phase, steers writes to one of NFUNC headers and registers the claim and
// read data. Assumes a request lasts one cycle; answers appear the next cycle.
module cfg_space_target
    import cfg_space_pkg::*;
#(
    parameter int                     NFUNC      = 2,
    parameter logic [NFUNC-1:0][15:0] VENDOR_ID  = {16'h5A17, 16'h5A17},
    parameter logic [NFUNC-1:0][15:0] DEVICE_ID  = {16'h0D20, 16'h0D10},
    parameter logic [NFUNC-1:0][7:0]  REVISION   = {8'h34, 8'h12},
    parameter logic [NFUNC-1:0][23:0] CLASS_CODE = {24'h010000, 24'h028000},
    parameter logic [NFUNC-1:0][7:0]  IRQ_PIN    = {8'h02, 8'h01},
    parameter logic [15:0]            STATUS_VAL = 16'h0280,
    parameter logic [15:0]            CMD_WMASK  = 16'h0145,
    parameter int                     BAR_LOG2   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              sleep,
    input  logic              req,
    input  logic              we,
    input  logic [NFUNC-1:0]  idsel,
    input  logic [31:0]       addr,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic              devsel,
    output logic              rd_valid,
    output logic [31:0]       rd_data
);

    logic                          claim;
    logic [NFUNC-1:0]              fsel;
    logic [IDX_W-1:0]              dw_idx;
    logic                          in_range;
    logic [NFUNC-1:0][DATA_W-1:0]  fn_rdata;
    logic [DATA_W-1:0]             sel_rdata;
    logic                          unused_inputs;

    // Upper address, function number, soft reset and sleep do not steer anything
    assign unused_inputs = ^{addr[31:8], soft_rst, sleep};

    cfg_decode #(.NFUNC(NFUNC)) u_decode (
        .req      (req),
        .addr_lo  (addr[7:0]),
        .idsel    (idsel),
        .claim    (claim),
        .fsel     (fsel),
        .dw_idx   (dw_idx),
        .in_range (in_range)
    );

    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
        cfg_func_regs #(
            .VENDOR_ID  (VENDOR_ID[f]),
            .DEVICE_ID  (DEVICE_ID[f]),
            .REVISION   (REVISION[f]),
            .CLASS_CODE (CLASS_CODE[f]),
            .STATUS_VAL (STATUS_VAL),
            .CMD_WMASK  (CMD_WMASK),
            .IRQ_PIN    (IRQ_PIN[f]),
            .BAR_LOG2   (BAR_LOG2)
        ) u_regs (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (we && fsel[f] && in_range),
            .idx   (dw_idx),
            .be    (be),
            .wdata (wdata),
            .rdata (fn_rdata[f])
        );
    end

    // Pick the selected function's word; out-of-range DWORDs read zero
    always_comb begin
        sel_rdata = '0;
        for (int f = 0; f < NFUNC; f++) begin
            if (fsel[f]) sel_rdata = sel_rdata | fn_rdata[f];
        end
        if (!in_range) sel_rdata = '0;
    end

    // Register the claim and masked read data for the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            devsel   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            devsel   <= claim;
            rd_valid <= claim && !we;
            rd_data  <= (claim && !we) ? (sel_rdata & lane_mask(be)) : '0;
        end
    end

endmodule

// File: rtl/cfg_space_target_chk.sv
// Port-level checker for cfg_space_target, attached with bind below.
// Assumes the same one-cycle request/answer timing as the design.
module cfg_space_target_chk
    import cfg_space_pkg::*;
#(
    parameter int NFUNC = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             sleep,
    input logic             req,
    input logic             we,
    input logic [NFUNC-1:0] idsel,
    input logic [31:0]      addr,
    input logic [3:0]       be,
    input logic             devsel,
    input logic             rd_valid,
    input logic [31:0]      rd_data
);

    assert_claim_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $countones(idsel) == 1 && addr[1:0] == 2'b00) |=> devsel);

    assert_badsel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && $countones(idsel) != 1) |=> !devsel);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!devsel && !rd_valid));

    assert_type0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && addr[1:0] != 2'b00) |=> !devsel);

    assert_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ((rd_data & ~lane_mask($past(be))) == '0));

    assert_wrquiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> (!rd_valid && rd_data == '0));

    assert_validclaim_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> devsel);

    assert_softrst_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req && (soft_rst || sleep) && $countones(idsel) == 1 && addr[1:0] == 2'b00) |=> devsel);

endmodule

bind cfg_space_target cfg_space_target_chk #(.NFUNC(NFUNC)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .sleep    (sleep),
    .req      (req),
    .we       (we),
    .idsel    (idsel),
    .addr     (addr),
    .be       (be),
    .devsel   (devsel),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
);

// File: tb/test_cfg_space_target.sv
// Scoreboard bench: the driver queues the expected answer of each request,
// the monitor pops and compares it one cycle later.
`timescale 1ns/1ps
module test_cfg_space_target;

    typedef struct {
        logic        claim;
        logic        rvalid;
        logic [31:0] data;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        sleep = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  idsel = 2'b00;
    logic [31:0] addr = '0;
    logic [3:0]  be = '0;
    logic [31:0] wdata = '0;
    logic        devsel;
    logic        rd_valid;
    logic [31:0] rd_data;

    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t sb[$];

    localparam logic [1:0] F0 = 2'b01;
    localparam logic [1:0] F1 = 2'b10;

    always #2 clk = ~clk;

    cfg_space_target i_cfg_space_target (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .sleep(sleep),
        .req(req), .we(we), .idsel(idsel), .addr(addr), .be(be),
        .wdata(wdata), .devsel(devsel), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [33:0] act, input logic [33:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one request and queue its expected answer
    task automatic cyc(input logic [1:0] sel, input logic [31:0] a, input logic w,
                       input logic [3:0] b, input logic [31:0] d,
                       input logic xclaim, input logic [31:0] xdata, input string tag);
        exp_t e;
        @(negedge clk);
        req = 1'b1; idsel = sel; addr = a; we = w; be = b; wdata = d;
        e.claim  = xclaim;
        e.rvalid = xclaim && !w;
        e.data   = (xclaim && !w) ? xdata : 32'h0;
        e.tag    = tag;
        sb.push_back(e);
        @(negedge clk);
        req = 1'b0; idsel = 2'b00; we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] xdata, input string tag);
        cyc(sel, a, 1'b0, b, 32'h0, 1'b1, xdata, tag);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] a, input logic [3:0] b,
                      input logic [31:0] d, input string tag);
        cyc(sel, a, 1'b1, b, d, 1'b1, 32'h0, tag);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare the front item one cycle after its request
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, {devsel, rd_valid, rd_data}, {e.claim, e.rvalid, e.data});
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        hw_reset();
        @(posedge clk); #1;
        check("R14 reset state", {devsel, rd_valid, rd_data}, 34'h0);

        // R14 / R5: first access right after reset; identity words
        rd(F0, 32'h0000_0000, 4'hF, 32'h0D10_5A17, "R14 R5 f0 ident");
        rd(F1, 32'h0000_0000, 4'hF, 32'h0D20_5A17, "R13 f1 ident");
        // R3: function number and upper bits ignored
        rd(F0, 32'hFFFF_F700, 4'hF, 32'h0D10_5A17, "R3 upper bits ignored");
        // R4: single lane read of sub-class
        rd(F0, 32'h0000_0008, 4'b0100, 32'h0080_0000, "R4 subclass byte");
        // R5: read-only identity and class
        wr(F0, 32'h0000_0000, 4'hF, 32'hFFFF_FFFF, "R5 wr ident");
        rd(F0, 32'h0000_0000, 4'hF, 32'h0D10_5A17, "R5 ident unchanged");
        wr(F0, 32'h0000_0008, 4'hF, 32'hFFFF_FFFF, "R5 wr class");
        rd(F0, 32'h0000_0008, 4'hF, 32'h0280_0012, "R5 class unchanged");
        // R11 / R6: command after reset, masked write
        rd(F0, 32'h0000_0004, 4'hF, 32'h0280_0000, "R11 cmd reset value");
        wr(F0, 32'h0000_0004, 4'hF, 32'hFFFF_FFFF, "R6 wr cmd");
        rd(F0, 32'h0000_0004, 4'hF, 32'h0280_0145, "R6 cmd mask");
        // R7: latency timer and header type
        wr(F0, 32'h0000_000C, 4'b0010, 32'hFFFF_FFFF, "R7 wr latency");
        rd(F0, 32'h0000_000C, 4'hF, 32'h0000_FF00, "R7 misc word");
        rd(F0, 32'h0000_000C, 4'b0100, 32'h0000_0000, "R7 header type single");
        // R8 / R4: base address sizing and lane-limited write
        wr(F0, 32'h0000_0010, 4'hF, 32'hFFFF_FFFF, "R8 wr bar");
        rd(F0, 32'h0000_0010, 4'hF, 32'hFFFF_FFE1, "R8 bar size");
        wr(F0, 32'h0000_0010, 4'b0001, 32'h0000_0000, "R4 wr bar lane0");
        rd(F0, 32'h0000_0010, 4'hF, 32'hFFFF_FF01, "R4 bar lane0 only");
        // R9 / R13: interrupt line per function
        wr(F0, 32'h0000_003C, 4'hF, 32'hFFFF_FF33, "R9 wr f0 line");
        wr(F1, 32'h0000_003C, 4'hF, 32'h0000_FF5C, "R9 wr f1 line");
        rd(F1, 32'h0000_003C, 4'hF, 32'h0000_025C, "R9 f1 line pin");
        rd(F0, 32'h0000_003C, 4'hF, 32'h0000_0133, "R13 f0 line kept");
        rd(F1, 32'h0000_0004, 4'hF, 32'h0280_0000, "R13 f1 cmd untouched");
        // R10 / R3: reserved and unimplemented DWORDs
        wr(F0, 32'h0000_0014, 4'hF, 32'hFFFF_FFFF, "R10 wr reserved");
        rd(F0, 32'h0000_0014, 4'hF, 32'h0000_0000, "R10 reserved zero");
        rd(F0, 32'h0000_0040, 4'hF, 32'h0000_0000, "R3 dword16 zero");
        wr(F0, 32'h0000_0050, 4'hF, 32'h0000_0000, "R3 wr dword20");
        rd(F0, 32'h0000_0010, 4'hF, 32'hFFFF_FF01, "R3 no alias to bar");
        // R2 / R1: rejected requests
        cyc(F0, 32'h0000_0001, 1'b0, 4'hF, 32'h0, 1'b0, 32'h0, "R2 type1 rejected");
        cyc(2'b00, 32'h0000_0000, 1'b0, 4'hF, 32'h0, 1'b0, 32'h0, "R1 no select");
        cyc(2'b11, 32'h0000_0000, 1'b0, 4'hF, 32'h0, 1'b0, 32'h0, "R1 both selects");
        cyc(2'b00, 32'h0000_003C, 1'b1, 4'hF, 32'h0, 1'b0, 32'h0, "R1 unclaimed wr");
        cyc(F0, 32'h0000_003E, 1'b1, 4'hF, 32'h0, 1'b0, 32'h0, "R2 unclaimed wr");
        rd(F0, 32'h0000_003C, 4'hF, 32'h0000_0133, "R1 line unchanged");
        // R12: write in the same cycle as soft reset and sleep
        @(negedge clk);
        soft_rst = 1'b1; sleep = 1'b1;
        wr(F0, 32'h0000_000C, 4'b0010, 32'h0000_4000, "R12 wr during soft reset");
        rd(F0, 32'h0000_0004, 4'hF, 32'h0280_0145, "R12 cmd kept");
        rd(F0, 32'h0000_000C, 4'hF, 32'h0000_4000, "R12 latency landed");
        @(negedge clk);
        soft_rst = 1'b0; sleep = 1'b0;
        // R11: hardware reset clears only the command word
        repeat (2) @(negedge clk);
        hw_reset();
        rd(F0, 32'h0000_0004, 4'hF, 32'h0280_0000, "R11 cmd cleared");
        rd(F0, 32'h0000_000C, 4'hF, 32'h0000_4000, "R11 latency kept");
        rd(F0, 32'h0000_0010, 4'hF, 32'hFFFF_FF01, "R11 bar kept");
        rd(F1, 32'h0000_003C, 4'hF, 32'h0000_025C, "R11 f1 line kept");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule